// File: doc/BRIEF.md
# Pointer Bounds Register Unit

This unit keeps a small file of bounds registers. Each register describes one pointer range as an inclusive lower limit and an inclusive upper limit. Two separate check operations test a 64-bit address against one limit of one register and return a one-cycle result that says whether the access would fault. A global check-off input turns every check into a no-op that never faults.

The unit can also move a register to and from a 32-byte bounds-table entry in memory through a single-word request/acknowledge port. A spill writes four words to the entry: the lower limit, the upper limit, the current pointer value and a zero pad word. A fill reads the first three words back. It then compares the stored pointer copy with the pointer supplied with the operation. When they differ, the unit does not raise an error. It loads the destination register with bounds that can never fault: lower limit zero and upper limit all ones. While a fill or spill is in progress the unit refuses new operations.

Top module: `bnd_unit`

## Requirements
- R1: After reset every register reads lower = 0 and upper = all ones, `busy` is low and `opReady` is high.
- R2: An accepted SET operation (opCode 0) writes lower = `opAddr` and upper = `opLimit` into register `opReg`. The read port shows the new value in the cycle after the accepting edge.
- R3: An accepted lower check (opCode 1) raises `chkValid` in the next cycle. `chkFault` is high then exactly when `opAddr` is below the lower limit of `opReg`, so equality passes.
- R4: An accepted upper check (opCode 2) raises `chkValid` in the next cycle. `chkFault` is high then exactly when `opAddr` is above the upper limit of `opReg`, so equality passes.
- R5: While `checkOff` is high at the accepting edge, both check operations still raise `chkValid` but never raise `chkFault`.
- R6: A spill (opCode 4) writes four words at `opEntry` + 0, 8, 16 and 24, in that order. The words carry the lower limit, the upper limit, `opAddr` (the pointer) and zero. The limits are the ones the register held when the spill was accepted, and the register is left unchanged.
- R7: A fill (opCode 3) reads words at `opEntry` + 0, 8 and 16, in that order. If the word at offset 16 equals `opAddr`, register `opReg` takes lower = word 0 and upper = word 8.
- R8: If the pointer copy read by a fill differs from `opAddr`, register `opReg` is set to lower = 0 and upper = all ones, and no other output signals an error.
- R9: `busy` is high from the cycle after a fill or spill is accepted until the edge that completes its last word. `seqDone` pulses for one cycle right after that edge. While `busy` is high, `opReady` is low and any presented operation is refused with no effect.
- R10: `memReq` holds its address, write flag and data stable until `memAck`. Each acknowledged cycle completes one word. A fill never touches the reserved word at offset 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| checkOff | input | 1 | Global check disable; checks report no fault |
| opValid | input | 1 | Operation presented this cycle |
| opCode | input | 3 | 0 set, 1 lower check, 2 upper check, 3 fill, 4 spill; others ignored |
| opReg | input | 2 | Register selected by the operation |
| opAddr | input | 64 | Check address, new lower limit, or pointer for fill/spill |
| opLimit | input | 64 | New upper limit for a set |
| opEntry | input | 64 | Byte address of the table entry for fill/spill |
| opReady | output | 1 | Operation would be accepted this cycle |
| chkValid | output | 1 | Check result valid |
| chkFault | output | 1 | Check result: access would fault |
| busy | output | 1 | Fill or spill in progress |
| seqDone | output | 1 | One-cycle pulse when a fill or spill ends |
| memReq | output | 1 | Memory word access requested |
| memWe | output | 1 | Access is a write |
| memAddr | output | 64 | Byte address of the word |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Access completes this cycle |
| memRdata | input | 64 | Read data, valid with memAck |
| rdSel | input | 2 | Register shown on the read port |
| rdLower | output | 64 | Lower limit of register rdSel |
| rdUpper | output | 64 | Upper limit of register rdSel |

## Verification
The hardest case to reach is an operation arriving while a table sequence is stalled on memory, because it only matters if it lands between two acknowledges. The memory model inserts varying wait states. The stimulus issues a set on another register directly behind a spill, so the set lands in the middle of the stalled sequence. The per-cycle register compare then shows the set never took effect. The fail-open path needs an entry whose pointer copy disagrees with the pointer. This is reached by spilling one register and filling it back twice, once with the spilled pointer and once with a pointer off by one. A hand-loaded entry with a nonzero reserved word shows that the pad word is never read.

// File: rtl/bnd_pkg.sv
package bnd_pkg;

  typedef enum logic [2:0] {
    OP_SET   = 3'd0,
    OP_CHKLO = 3'd1,
    OP_CHKHI = 3'd2,
    OP_FILL  = 3'd3,
    OP_SPILL = 3'd4
  } opKindE;

  // word positions inside a table entry; fill stops at the pointer copy
  localparam int unsigned LO_WORD  = 0;
  localparam int unsigned HI_WORD  = 1;
  localparam int unsigned PTR_WORD = 2;

  typedef struct packed {
    logic setWr;
    logic chkLo;
    logic chkHi;
    logic start;
    logic grab;
    logic commit;
  } ctlStrbT;

endpackage

// File: rtl/bnd_ctrl.sv
module bnd_ctrl
  import bnd_pkg::*;
#(
  parameter int unsigned EntryWords = 4,
  parameter int unsigned FillWords  = PTR_WORD + 1,
  localparam int unsigned IdxW = $clog2(EntryWords)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            opValid,
  input  logic [2:0]      opCode,
  input  logic            memAck,
  output ctlStrbT         strb,
  output logic            opReady,
  output logic            busy,
  output logic            seqDone,
  output logic            memReq,
  output logic            memWe,
  output logic [IdxW-1:0] wordIdx
);

  logic            xferQ;
  logic            spillQ;
  logic            doneQ;
  logic [IdxW-1:0] idxQ;
  logic [IdxW-1:0] lastIdx;
  logic            accept;
  logic            lastAck;

  assign accept  = opValid && !xferQ;
  assign lastIdx = spillQ ? IdxW'(EntryWords - 1) : IdxW'(FillWords - 1);
  assign lastAck = xferQ && memAck && (idxQ == lastIdx);

  always_comb begin
    strb        = '0;
    strb.setWr  = accept && (opCode == OP_SET);
    strb.chkLo  = accept && (opCode == OP_CHKLO);
    strb.chkHi  = accept && (opCode == OP_CHKHI);
    strb.start  = accept && ((opCode == OP_FILL) || (opCode == OP_SPILL));
    strb.grab   = xferQ && memAck && !spillQ;
    strb.commit = lastAck && !spillQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xferQ  <= 1'b0;
      spillQ <= 1'b0;
      idxQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastAck;
      if (strb.start) begin
        xferQ  <= 1'b1;
        spillQ <= (opCode == OP_SPILL);
        idxQ   <= '0;
      end else if (xferQ && memAck) begin
        if (idxQ == lastIdx) xferQ <= 1'b0;
        else                 idxQ  <= idxQ + 1'b1;
      end
    end
  end

  assign opReady = !xferQ;
  assign busy    = xferQ;
  assign seqDone = doneQ;
  assign memReq  = xferQ;
  assign memWe   = xferQ && spillQ;
  assign wordIdx = idxQ;

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |=> !seqDone);

  // R9: busy only drops together with the completion pulse
  assert_done_on_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> seqDone);

  // R10: an unacknowledged request keeps its word position
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq && $stable(wordIdx) && $stable(memWe));

endmodule

// File: rtl/bnd_data.sv
module bnd_data
  import bnd_pkg::*;
#(
  parameter int unsigned DataW      = 64,
  parameter int unsigned NumRegs    = 4,
  parameter int unsigned EntryWords = 4,
  localparam int unsigned SelW      = $clog2(NumRegs),
  localparam int unsigned IdxW      = $clog2(EntryWords),
  localparam int unsigned WordBytes = DataW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrbT          strb,
  input  logic             checkOff,
  input  logic [SelW-1:0]  opReg,
  input  logic [DataW-1:0] opAddr,
  input  logic [DataW-1:0] opLimit,
  input  logic [DataW-1:0] opEntry,
  input  logic [IdxW-1:0]  wordIdx,
  input  logic [DataW-1:0] memRdata,
  input  logic [SelW-1:0]  rdSel,
  output logic [DataW-1:0] memAddr,
  output logic [DataW-1:0] memWdata,
  output logic             chkValid,
  output logic             chkFault,
  output logic [DataW-1:0] rdLower,
  output logic [DataW-1:0] rdUpper
);

  logic [NumRegs-1:0][DataW-1:0] loAll;
  logic [NumRegs-1:0][DataW-1:0] hiAll;

  logic [DataW-1:0] entryQ;
  logic [DataW-1:0] ptrQ;
  logic [SelW-1:0]  dstQ;
  logic [DataW-1:0] wordLoQ;
  logic [DataW-1:0] wordHiQ;
  logic             ptrMatch;
  logic [DataW-1:0] fillLo;
  logic [DataW-1:0] fillHi;

  assign ptrMatch = (memRdata == ptrQ);
  assign fillLo   = ptrMatch ? wordLoQ : '0;
  assign fillHi   = ptrMatch ? wordHiQ : '1;

  for (genvar g = 0; g < NumRegs; g++) begin : gReg
    logic             setHit;
    logic             fillHit;
    logic [DataW-1:0] loQ;
    logic [DataW-1:0] hiQ;

    assign setHit  = strb.setWr && (opReg == SelW'(g));
    assign fillHit = strb.commit && (dstQ == SelW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        loQ <= '0;
        hiQ <= '1;
      end else if (setHit) begin
        loQ <= opAddr;
        hiQ <= opLimit;
      end else if (fillHit) begin
        loQ <= fillLo;
        hiQ <= fillHi;
      end
    end

    assign loAll[g] = loQ;
    assign hiAll[g] = hiQ;
  end

  // staging for the table sequence: spill snapshots the register, fill overwrites with read words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entryQ  <= '0;
      ptrQ    <= '0;
      dstQ    <= '0;
      wordLoQ <= '0;
      wordHiQ <= '0;
    end else if (strb.start) begin
      entryQ  <= opEntry;
      ptrQ    <= opAddr;
      dstQ    <= opReg;
      wordLoQ <= loAll[opReg];
      wordHiQ <= hiAll[opReg];
    end else if (strb.grab) begin
      if (wordIdx == IdxW'(LO_WORD)) wordLoQ <= memRdata;
      if (wordIdx == IdxW'(HI_WORD)) wordHiQ <= memRdata;
    end
  end

  assign memAddr = entryQ + DataW'(wordIdx) * DataW'(WordBytes);

  always_comb begin
    if (wordIdx == IdxW'(LO_WORD))       memWdata = wordLoQ;
    else if (wordIdx == IdxW'(HI_WORD))  memWdata = wordHiQ;
    else if (wordIdx == IdxW'(PTR_WORD)) memWdata = ptrQ;
    else                                 memWdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chkValid <= 1'b0;
      chkFault <= 1'b0;
    end else begin
      chkValid <= strb.chkLo || strb.chkHi;
      chkFault <= !checkOff &&
                  ((strb.chkLo && (opAddr < loAll[opReg])) ||
                   (strb.chkHi && (opAddr > hiAll[opReg])));
    end
  end

  assign rdLower = loAll[rdSel];
  assign rdUpper = hiAll[rdSel];

  // R5: with checking off, a check reports a result but never a fault
  assert_off_nofault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.chkLo || strb.chkHi) && checkOff |=> chkValid && !chkFault);

  // R3 / R4: a fault is only ever reported as a check result
  assert_fault_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chkFault |-> chkValid);

endmodule

// File: rtl/bnd_unit.sv
module bnd_unit
  import bnd_pkg::*;
#(
  parameter int unsigned DataW      = 64,
  parameter int unsigned NumRegs    = 4,
  parameter int unsigned EntryWords = 4,
  localparam int unsigned SelW      = $clog2(NumRegs),
  localparam int unsigned IdxW      = $clog2(EntryWords)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             checkOff,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [SelW-1:0]  opReg,
  input  logic [DataW-1:0] opAddr,
  input  logic [DataW-1:0] opLimit,
  input  logic [DataW-1:0] opEntry,
  output logic             opReady,
  output logic             chkValid,
  output logic             chkFault,
  output logic             busy,
  output logic             seqDone,
  output logic             memReq,
  output logic             memWe,
  output logic [DataW-1:0] memAddr,
  output logic [DataW-1:0] memWdata,
  input  logic             memAck,
  input  logic [DataW-1:0] memRdata,
  input  logic [SelW-1:0]  rdSel,
  output logic [DataW-1:0] rdLower,
  output logic [DataW-1:0] rdUpper
);

  ctlStrbT         strb;
  logic [IdxW-1:0] wordIdx;

  bnd_ctrl #(
    .EntryWords (EntryWords)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .opValid (opValid),
    .opCode  (opCode),
    .memAck  (memAck),
    .strb    (strb),
    .opReady (opReady),
    .busy    (busy),
    .seqDone (seqDone),
    .memReq  (memReq),
    .memWe   (memWe),
    .wordIdx (wordIdx)
  );

  bnd_data #(
    .DataW      (DataW),
    .NumRegs    (NumRegs),
    .EntryWords (EntryWords)
  ) i_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .checkOff (checkOff),
    .opReg    (opReg),
    .opAddr   (opAddr),
    .opLimit  (opLimit),
    .opEntry  (opEntry),
    .wordIdx  (wordIdx),
    .memRdata (memRdata),
    .rdSel    (rdSel),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .chkValid (chkValid),
    .chkFault (chkFault),
    .rdLower  (rdLower),
    .rdUpper  (rdUpper)
  );

endmodule

// File: tb/test_bnd_unit.sv
module test_bnd_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        checkOff = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  opReg = '0;
  logic [63:0] opAddr = '0;
  logic [63:0] opLimit = '0;
  logic [63:0] opEntry = '0;
  logic        opReady, chkValid, chkFault, busy, seqDone, memReq, memWe;
  logic [63:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [63:0] memRdata = '0;
  logic [1:0]  rdSel = '0;
  logic [63:0] rdLower, rdUpper;

  bnd_unit i_bnd_unit (
    .clk(clk), .rst_n(rst_n), .checkOff(checkOff), .opValid(opValid),
    .opCode(opCode), .opReg(opReg), .opAddr(opAddr), .opLimit(opLimit),
    .opEntry(opEntry), .opReady(opReady), .chkValid(chkValid),
    .chkFault(chkFault), .busy(busy), .seqDone(seqDone), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .rdSel(rdSel), .rdLower(rdLower), .rdUpper(rdUpper)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: word store with varying wait states
  logic [63:0] memArr [logic [63:0]];
  int waitCnt = 1;
  int delaySel = 1;

  // reference model state
  logic [63:0] mLo [4];
  logic [63:0] mHi [4];
  string       mTag [4];
  bit          mBusy, mDone, mChkV, mChkF, mSpill;
  string       mChkTag = "R3";
  int          mIdx, mLast;
  logic [63:0] mEntry, mPtr;
  logic [63:0] mWord [2];
  int          mDst;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        mLo[i] = '0; mHi[i] = '1; mTag[i] = "R1";
      end
      mBusy = 0; mDone = 0; mChkV = 0; mChkF = 0; mSpill = 0; mIdx = 0; mLast = 0;
    end else begin
      mDone = 0; mChkV = 0; mChkF = 0;
      if (mBusy) begin
        if (memAck) begin
          if (!mSpill && mIdx < 2) mWord[mIdx] = memRdata;
          if (mIdx == mLast) begin
            mBusy = 0; mDone = 1;
            if (!mSpill) begin
              if (memRdata == mPtr) begin
                mLo[mDst] = mWord[0]; mHi[mDst] = mWord[1]; mTag[mDst] = "R7";
              end else begin
                mLo[mDst] = '0; mHi[mDst] = '1; mTag[mDst] = "R8";
              end
            end
          end else mIdx++;
        end
      end else if (opValid) begin
        case (opCode)
          3'd0: begin mLo[opReg] = opAddr; mHi[opReg] = opLimit; mTag[opReg] = "R2"; end
          3'd1: begin mChkV = 1; mChkF = !checkOff && (opAddr < mLo[opReg]);
                      mChkTag = checkOff ? "R5" : "R3"; end
          3'd2: begin mChkV = 1; mChkF = !checkOff && (opAddr > mHi[opReg]);
                      mChkTag = checkOff ? "R5" : "R4"; end
          3'd3, 3'd4: begin
            mBusy = 1; mSpill = (opCode == 3'd4); mIdx = 0;
            mLast = mSpill ? 3 : 2; mEntry = opEntry; mPtr = opAddr; mDst = opReg;
            mWord[0] = mLo[opReg]; mWord[1] = mHi[opReg];
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, then memory response for the coming edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(opReady == !mBusy, "R9", "opReady", opReady, !mBusy);
      check(busy == mBusy, "R9", "busy", busy, mBusy);
      check(seqDone == mDone, "R9", "seqDone", seqDone, mDone);
      check(chkValid == mChkV, mChkTag, "chkValid", chkValid, mChkV);
      check(chkFault == mChkF, mChkTag, "chkFault", chkFault, mChkF);
      check(rdLower == mLo[rdSel], mTag[rdSel], "rdLower", rdLower, mLo[rdSel]);
      check(rdUpper == mHi[rdSel], mTag[rdSel], "rdUpper", rdUpper, mHi[rdSel]);
      check(memReq == mBusy, "R10", "memReq", memReq, mBusy);
      if (mBusy) begin
        check(memAddr == mEntry + 64'(mIdx * 8), mSpill ? "R6" : "R7", "memAddr",
              memAddr, mEntry + 64'(mIdx * 8));
        check(memWe == mSpill, "R10", "memWe", memWe, mSpill);
        if (mSpill) begin
          logic [63:0] expW;
          expW = (mIdx == 0) ? mWord[0] : (mIdx == 1) ? mWord[1] : (mIdx == 2) ? mPtr : 64'd0;
          check(memWdata == expW, "R6", "memWdata", memWdata, expW);
        end
        if (!mSpill) check(mIdx < 3, "R10", "fill word index", 64'(mIdx), 64'd2);
      end
    end
    memAck = 1'b0;
    if (rst_n && memReq) begin
      if (waitCnt == 0) begin
        memAck = 1'b1;
        if (memWe) memArr[memAddr] = memWdata;
        else memRdata = memArr.exists(memAddr) ? memArr[memAddr] : 64'd0;
        delaySel = (delaySel * 5 + 3) % 4;
        waitCnt = delaySel;
      end else waitCnt--;
    end
  end

  always @(posedge clk) begin
    #1 rdSel <= rdSel + 2'd1;
  end

  task automatic issue(input logic [2:0] code, input logic [1:0] r,
                       input logic [63:0] a, input logic [63:0] l, input logic [63:0] e);
    @(posedge clk); #1;
    opValid = 1'b1; opCode = code; opReg = r; opAddr = a; opLimit = l; opEntry = e;
    @(posedge clk); #1;
    opValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) begin @(posedge clk); #1; end
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset contents on all four registers
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rdLower == 64'd0, "R1", "reset lower", rdLower, 64'd0);
      check(rdUpper == '1, "R1", "reset upper", rdUpper, '1);
      check(busy == 1'b0 && opReady == 1'b1, "R1", "reset busy/ready", {busy, opReady}, 64'd1);
    end
    // R2 then R3/R4 boundaries
    issue(3'd0, 2'd1, 64'h1000, 64'h1fff, 0);
    issue(3'd1, 2'd1, 64'h0fff, 0, 0);
    issue(3'd1, 2'd1, 64'h1000, 0, 0);
    issue(3'd2, 2'd1, 64'h1fff, 0, 0);
    issue(3'd2, 2'd1, 64'h2000, 0, 0);
    issue(3'd1, 2'd0, 64'h0, 0, 0);
    issue(3'd2, 2'd0, '1, 0, 0);
    // R5: checks disabled
    @(posedge clk); #1 checkOff = 1'b1;
    issue(3'd1, 2'd1, 64'h5, 0, 0);
    issue(3'd2, 2'd1, 64'hffff, 0, 0);
    @(posedge clk); #1 checkOff = 1'b0;
    issue(3'd2, 2'd1, 64'hffff, 0, 0);
    // R6: spill with a refused set arriving behind it (R9)
    issue(3'd4, 2'd1, 64'habc0, 0, 64'h100);
    issue(3'd0, 2'd0, 64'h7, 64'h8, 0);
    issue(3'd1, 2'd1, 64'h0, 0, 0);
    waitIdle();
    idleCycles(4);
    // R7: fill back with matching pointer
    issue(3'd3, 2'd2, 64'habc0, 0, 64'h100);
    waitIdle();
    idleCycles(4);
    // R8: fill with mismatching pointer fails open
    issue(3'd0, 2'd3, 64'h40, 64'h50, 0);
    issue(3'd3, 2'd3, 64'habc1, 0, 64'h100);
    waitIdle();
    idleCycles(4);
    issue(3'd1, 2'd3, 64'h0, 0, 0);
    // R7 / R10: hand-loaded entry with a nonzero reserved word
    memArr[64'h200] = 64'h3000; memArr[64'h208] = 64'h3fff;
    memArr[64'h210] = 64'hdead0; memArr[64'h218] = 64'hffff_0000_ffff_0000;
    issue(3'd3, 2'd0, 64'hdead0, 0, 64'h200);
    waitIdle();
    issue(3'd1, 2'd0, 64'h2fff, 0, 0);
    issue(3'd2, 2'd0, 64'h4000, 0, 0);
    issue(3'd5, 2'd0, 64'h1, 64'h2, 0);
    idleCycles(6);
    check(memArr[64'h218] == 64'hffff_0000_ffff_0000, "R10", "reserved word untouched",
          memArr[64'h218], 64'hffff_0000_ffff_0000);
    check(memArr[64'h118] == 64'd0, "R6", "spill pad word", memArr[64'h118], 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule